// File: doc/BRIEF.md
# Split-Transaction Bus Master Arbiter

This block is the master-side tenure controller for a bus whose address and data phases run independently. A core pushes read and write transactions into a small in-order queue. For each entry the block first wins an address tenure: it requests the bus, qualifies the grant against the external busy and retry lines, holds its address-busy output until the acknowledge, and opens a one-cycle window in which the system may retry that address. An entry whose address has been acknowledged becomes a candidate for a data tenure. The block qualifies a separate data grant, holds its data-busy output for a fixed number of beats, and removes the entry when the last beat completes.

Several entries can have their address phases finished before any data phase runs, so address tenures are pipelined ahead of data. Data tenures normally run oldest first. A write-only grant input lets the oldest acknowledged write go ahead of an older acknowledged read. When no write is waiting, that input lets a read go. A data retry cuts the running tenure short, and the entry keeps its place for a later grant.

Top module: `splitbus_master`

## Requirements
- R1: After reset, bus_req, addr_busy_out, data_busy_out and data_last are 0 and req_ready is 1.
- R2: bus_req is 1 while some queued entry still needs its address tenure, the block does not own the address bus and parked is 0. Otherwise it is 0.
- R3: An address grant is taken only in a cycle where addr_grant is 1, addr_busy_in is 0, addr_retry is 0 and an entry needs an address tenure. addr_busy_out is then 1 from the next cycle up to and including the cycle in which addr_ack is 1, and 0 in the cycle after that.
- R4: With parked at 1, bus_req stays 0, yet a grant that meets the other conditions of R3 is still taken.
- R5: addr_retry in the cycle right after an entry's addr_ack cancels that entry's data tenure. A data grant in that cycle is refused, and the entry requests the address bus again. addr_retry in any other cycle does not stop a data grant.
- R6: A data tenure starts only in a cycle where data_grant is 1, data_busy_in is 0, data_retry is 0 and no paired address retry applies. data_busy_out rises in the next cycle.
- R7: With write_only at 0, data tenures run in queue order. data_write is 0 for a read tenure and 1 for a write tenure.
- R8: With write_only at 1, the oldest acknowledged write gets the data bus ahead of an older acknowledged read. If no acknowledged write is waiting, an acknowledged read is granted.
- R9: A tenure with req_burst at 0 holds data_busy_out for 1 cycle. A tenure with req_burst at 1 holds it for BURST_BEATS cycles (default 4). data_last is 1 only in the final busy cycle, and the entry is removed after it.
- R10: data_retry during a tenure drops data_busy_out in the next cycle. The entry is kept without a new address tenure, and its next grant runs the full beat count.
- R11: req_ready is 0 when DEPTH (default 2) entries are queued. A req_valid in that state is dropped and never produces a tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core pushes a transaction this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst of BURST_BEATS beats, 0 = single beat |
| req_ready | output | 1 | Queue has a free slot |
| bus_req | output | 1 | Address bus request |
| addr_grant | input | 1 | Address bus grant from the system |
| addr_busy_in | input | 1 | Another master holds the address bus |
| addr_retry | input | 1 | Address retry from the bus |
| addr_ack | input | 1 | Address acknowledge, ends the address tenure |
| parked | input | 1 | The system has parked the address bus on this master |
| addr_busy_out | output | 1 | This master owns the address bus |
| data_grant | input | 1 | Data bus grant |
| data_busy_in | input | 1 | Another master holds the data bus |
| data_retry | input | 1 | Data retry from the system |
| write_only | input | 1 | Write-only data grant qualifier |
| data_busy_out | output | 1 | This master owns the data bus |
| data_last | output | 1 | Final beat of the current data tenure |
| data_write | output | 1 | Current data tenure is a write |

## Verification
The hardest case to reach is the paired address retry. It refuses a data grant only in the single cycle after that entry's acknowledge, and it must leave a later, unrelated retry without effect. The bench lands data_grant and addr_retry together in exactly that window cycle, and checks that data_busy_out stays low and bus_req returns. It then repeats the address phase, lets the window pass, and raises addr_retry together with the data grant to show the tenure now starts. Reordering is reached by completing both address phases while data_grant stays low, so that an older read and a younger write are both waiting when write_only is applied.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [1:0] {
        ADR_WAIT = 2'd0,
        ADR_OWN  = 2'd1,
        ADR_DONE = 2'd2
    } adr_st_e;

    typedef struct packed {
        logic    used;
        logic    is_wr;
        logic    is_burst;
        adr_st_e adr;
        logic    dat_on;
        logic    rty_win;
    } slot_t;

    function automatic logic slot_needs_addr(input slot_t s);
        return s.used && (s.adr == ADR_WAIT);
    endfunction

    function automatic logic slot_ready_data(input slot_t s);
        return s.used && (s.adr == ADR_DONE) && !s.dat_on;
    endfunction

endpackage

// File: rtl/sbm_addr_ctl.sv
module sbm_addr_ctl #(
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] need,
    input  logic             owning,
    input  logic             parked,
    input  logic             addr_grant,
    input  logic             addr_busy_in,
    input  logic             addr_retry,
    output logic             bus_req,
    output logic [DEPTH-1:0] take
);
    logic any_need;
    logic qual;
    logic found;

    always_comb begin
        any_need = |need;
        bus_req  = any_need && !owning && !parked;
        qual     = any_need && !owning && addr_grant && !addr_busy_in && !addr_retry;
        take     = '0;
        found    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (need[i] && !found) begin
                take[i] = qual;
                found   = 1'b1;
            end
        end
    end

    // R3
    agrant_take_chk: assert property (@(posedge clk) disable iff (rst)
        (|take) |=> owning);

    // R3
    aown_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(owning) |-> $past(addr_grant && !addr_busy_in && !addr_retry));

endmodule

// File: rtl/sbm_data_sel.sv
module sbm_data_sel #(
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] elig,
    input  logic [DEPTH-1:0] wr,
    input  logic [DEPTH-1:0] win,
    input  logic             busy,
    input  logic             write_only,
    input  logic             data_grant,
    input  logic             data_busy_in,
    input  logic             data_retry,
    input  logic             addr_retry,
    output logic             start,
    output logic [DEPTH-1:0] pick
);
    logic [DEPTH-1:0] pool;
    logic [DEPTH-1:0] cand;
    logic             found;
    logic             paired_rty;

    always_comb begin
        pool  = (write_only && |(elig & wr)) ? (elig & wr) : elig;
        cand  = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pool[i] && !found) begin
                cand[i] = 1'b1;
                found   = 1'b1;
            end
        end
        paired_rty = addr_retry && |(cand & win);
        start = found && !busy && data_grant && !data_busy_in && !data_retry && !paired_rty;
        pick  = start ? cand : '0;
    end

    // R6
    dstart_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R6
    dbusy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(data_grant && !data_busy_in && !data_retry));

endmodule

// File: rtl/sbm_beat_ctr.sv
module sbm_beat_ctr #(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic burst,
    input  logic cut,
    output logic active,
    output logic last
);
    localparam int unsigned CW   = $clog2(BEATS + 1);
    localparam int unsigned ONE  = 1;
    localparam logic [CW-1:0] LEN_BURST = BEATS[CW-1:0];
    localparam logic [CW-1:0] LEN_ONE   = ONE[CW-1:0];

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    assign last = active && (cnt == len - LEN_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            len    <= LEN_ONE;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            len    <= burst ? LEN_BURST : LEN_ONE;
        end else if (active) begin
            if (cut || last) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + LEN_ONE;
            end
        end
    end

    // R10
    cut_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cut) |=> !active);

    // R9
    end_only_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(last || cut));

endmodule

// File: rtl/splitbus_master.sv
module splitbus_master
    import sbm_pkg::*;
#(
    parameter int unsigned DEPTH       = 2,
    parameter int unsigned BURST_BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_burst,
    output logic req_ready,
    output logic bus_req,
    input  logic addr_grant,
    input  logic addr_busy_in,
    input  logic addr_retry,
    input  logic addr_ack,
    input  logic parked,
    output logic addr_busy_out,
    input  logic data_grant,
    input  logic data_busy_in,
    input  logic data_retry,
    input  logic write_only,
    output logic data_busy_out,
    output logic data_last,
    output logic data_write
);
    slot_t q    [DEPTH];
    slot_t q_nx [DEPTH];

    logic [DEPTH-1:0] need_v, elig_v, wr_v, win_v, own_v, dat_v, burst_v;
    logic [DEPTH-1:0] a_take, d_pick;
    logic             d_start, b_active, b_last, push;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign need_v[g]  = slot_needs_addr(q[g]);
        assign elig_v[g]  = slot_ready_data(q[g]);
        assign wr_v[g]    = q[g].used && q[g].is_wr;
        assign burst_v[g] = q[g].used && q[g].is_burst;
        assign win_v[g]   = q[g].used && q[g].rty_win;
        assign own_v[g]   = q[g].used && (q[g].adr == ADR_OWN);
        assign dat_v[g]   = q[g].used && q[g].dat_on;
    end

    assign req_ready     = !q[DEPTH-1].used;
    assign push          = req_valid && req_ready;
    assign addr_busy_out = |own_v;
    assign data_busy_out = b_active;
    assign data_last     = b_last;
    assign data_write    = |(dat_v & wr_v);

    sbm_addr_ctl #(.DEPTH(DEPTH)) u_adr (
        .clk(clk), .rst(rst), .need(need_v), .owning(addr_busy_out),
        .parked(parked), .addr_grant(addr_grant), .addr_busy_in(addr_busy_in),
        .addr_retry(addr_retry), .bus_req(bus_req), .take(a_take)
    );

    sbm_data_sel #(.DEPTH(DEPTH)) u_dsel (
        .clk(clk), .rst(rst), .elig(elig_v), .wr(wr_v), .win(win_v),
        .busy(b_active), .write_only(write_only), .data_grant(data_grant),
        .data_busy_in(data_busy_in), .data_retry(data_retry),
        .addr_retry(addr_retry), .start(d_start), .pick(d_pick)
    );

    sbm_beat_ctr #(.BEATS(BURST_BEATS)) u_beat (
        .clk(clk), .rst(rst), .start(d_start), .burst(|(d_pick & burst_v)),
        .cut(data_retry), .active(b_active), .last(b_last)
    );

    always_comb begin
        slot_t upd [DEPTH];
        slot_t fresh;
        int    k;
        for (int i = 0; i < DEPTH; i++) begin
            upd[i]         = q[i];
            upd[i].rty_win = 1'b0;
            if (a_take[i]) upd[i].adr = ADR_OWN;
            if (own_v[i] && addr_ack) begin
                upd[i].adr     = ADR_DONE;
                upd[i].rty_win = 1'b1;
            end
            if (win_v[i] && addr_retry) upd[i].adr = ADR_WAIT;
            if (d_pick[i]) upd[i].dat_on = 1'b1;
            if (dat_v[i] && data_retry) upd[i].dat_on = 1'b0;
            if (dat_v[i] && b_last && !data_retry) upd[i].used = 1'b0;
        end
        fresh          = '0;
        fresh.used     = 1'b1;
        fresh.is_wr    = req_write;
        fresh.is_burst = req_burst;
        fresh.adr      = ADR_WAIT;
        for (int j = 0; j < DEPTH; j++) q_nx[j] = '0;
        k = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (upd[i].used) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == k) q_nx[j] = upd[i];
                end
                k = k + 1;
            end
        end
        for (int j = 0; j < DEPTH; j++) begin
            if (push && (j == k)) q_nx[j] = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            q <= q_nx;
        end
    end

    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_v));

    // R6
    one_data_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dat_v));

    // R5
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_retry && |win_v) |=> |need_v);

    // R8
    wo_first_chk: assert property (@(posedge clk) disable iff (rst)
        (d_start && write_only && |(elig_v & wr_v)) |=> data_write);

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !b_last) |=> !req_ready);

endmodule

// File: tb/sim_splitbus_master.sv
module sim_splitbus_master;
    localparam int unsigned BEATS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_burst = 0;
    logic addr_grant = 0, addr_busy_in = 0, addr_retry = 0, addr_ack = 0, parked = 0;
    logic data_grant = 0, data_busy_in = 0, data_retry = 0, write_only = 0;
    logic req_ready, bus_req, addr_busy_out, data_busy_out, data_last, data_write;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    splitbus_master #(.DEPTH(2), .BURST_BEATS(BEATS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_ready(req_ready), .bus_req(bus_req),
        .addr_grant(addr_grant), .addr_busy_in(addr_busy_in), .addr_retry(addr_retry),
        .addr_ack(addr_ack), .parked(parked), .addr_busy_out(addr_busy_out),
        .data_grant(data_grant), .data_busy_in(data_busy_in), .data_retry(data_retry),
        .write_only(write_only), .data_busy_out(data_busy_out), .data_last(data_last),
        .data_write(data_write)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        #1;
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic enq(input logic w, input logic b);
        req_valid = 1; req_write = w; req_burst = b;
        tick();
        req_valid = 0; req_write = 0; req_burst = 0;
    endtask

    task automatic adr();
        addr_grant = 1; tick(); addr_grant = 0;
        addr_ack = 1; tick(); addr_ack = 0;
    endtask

    task automatic t_reset();
        chk("R1 bus_req", bus_req, 0);
        chk("R1 addr_busy_out", addr_busy_out, 0);
        chk("R1 data_busy_out", data_busy_out, 0);
        chk("R1 data_last", data_last, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    task automatic t_single_read();
        enq(0, 0);
        chk("R2 request raised", bus_req, 1);
        chk("R3 not owner yet", addr_busy_out, 0);
        addr_grant = 1; tick(); addr_grant = 0;
        chk("R3 owner after grant", addr_busy_out, 1);
        chk("R2 request dropped while owner", bus_req, 0);
        addr_ack = 1; tick(); addr_ack = 0;
        chk("R3 owner released after ack", addr_busy_out, 0);
        data_grant = 1; tick(); data_grant = 0;
        chk("R6 data busy after grant", data_busy_out, 1);
        chk("R9 single last", data_last, 1);
        chk("R7 read flag", data_write, 0);
        tick();
        chk("R9 single ends", data_busy_out, 0);
        chk("R9 slot freed", req_ready, 1);
        chk("R2 nothing left", bus_req, 0);
    endtask

    task automatic t_parked();
        parked = 1;
        enq(1, 0);
        chk("R4 no request when parked", bus_req, 0);
        addr_grant = 1; tick(); addr_grant = 0;
        chk("R4 parked grant taken", addr_busy_out, 1);
        addr_ack = 1; tick(); addr_ack = 0;
        parked = 0;
        data_grant = 1; tick(); data_grant = 0;
        chk("R7 write flag", data_write, 1);
        tick();
    endtask

    task automatic t_addr_block();
        enq(0, 0);
        addr_grant = 1; addr_busy_in = 1; tick();
        chk("R3 blocked by addr busy", addr_busy_out, 0);
        addr_busy_in = 0; addr_retry = 1; tick();
        chk("R3 blocked by retry", addr_busy_out, 0);
        addr_retry = 0; tick(); addr_grant = 0;
        chk("R3 taken when clear", addr_busy_out, 1);
        addr_ack = 1; tick(); addr_ack = 0;
        tick();
        data_grant = 1; data_busy_in = 1; tick();
        chk("R6 blocked by data busy", data_busy_out, 0);
        data_busy_in = 0; data_retry = 1; tick();
        chk("R6 blocked by data retry", data_busy_out, 0);
        data_retry = 0; tick(); data_grant = 0;
        chk("R6 started when clear", data_busy_out, 1);
        tick();
    endtask

    task automatic t_addr_retry();
        enq(0, 0);
        adr();
        addr_retry = 1; data_grant = 1; tick(); addr_retry = 0; data_grant = 0;
        chk("R5 paired retry refuses data", data_busy_out, 0);
        chk("R5 address re-requested", bus_req, 1);
        adr();
        tick();
        addr_retry = 1; data_grant = 1; tick(); addr_retry = 0; data_grant = 0;
        chk("R5 unpaired retry ignored", data_busy_out, 1);
        tick();
        chk("R5 done after single", data_busy_out, 0);
        chk("R5 no stray request", bus_req, 0);
    endtask

    task automatic t_reorder();
        enq(0, 0);
        enq(1, 0);
        adr();
        adr();
        tick();
        data_grant = 1; write_only = 1; tick(); data_grant = 0;
        chk("R8 write goes first", data_write, 1);
        chk("R8 write tenure busy", data_busy_out, 1);
        tick();
        data_grant = 1; tick(); data_grant = 0; write_only = 0;
        chk("R8 read granted with no write", data_busy_out, 1);
        chk("R8 read flag", data_write, 0);
        tick();
        chk("R8 queue empty", bus_req, 0);
    endtask

    task automatic t_in_order_full();
        enq(0, 0);
        enq(1, 0);
        chk("R11 full", req_ready, 0);
        enq(1, 1);
        adr();
        adr();
        tick();
        data_grant = 1; tick(); data_grant = 0;
        chk("R7 oldest read first", data_write, 0);
        tick();
        data_grant = 1; tick(); data_grant = 0;
        chk("R7 then write", data_write, 1);
        tick();
        chk("R11 dropped push left no entry", bus_req, 0);
        chk("R11 ready again", req_ready, 1);
        chk("R11 no extra tenure", data_busy_out, 0);
    endtask

    task automatic t_burst();
        enq(0, 1);
        adr();
        data_grant = 1; tick(); data_grant = 0;
        for (int b = 1; b <= BEATS; b++) begin
            chk("R9 burst busy", data_busy_out, 1);
            chk("R9 burst last", data_last, (b == BEATS));
            tick();
        end
        chk("R9 burst released", data_busy_out, 0);
    endtask

    task automatic t_data_retry();
        enq(1, 1);
        adr();
        data_grant = 1; tick(); data_grant = 0;
        tick();
        data_retry = 1; tick(); data_retry = 0;
        chk("R10 busy dropped", data_busy_out, 0);
        chk("R10 no new address", bus_req, 0);
        chk("R10 entry kept", u0_dummy_ready(), 1);
        data_grant = 1; tick(); data_grant = 0;
        chk("R10 regranted write", data_write, 1);
        for (int b = 1; b <= BEATS; b++) begin
            chk("R10 full length busy", data_busy_out, 1);
            chk("R10 last beat", data_last, (b == BEATS));
            tick();
        end
        chk("R10 finished", data_busy_out, 0);
    endtask

    function automatic logic u0_dummy_ready();
        return req_ready;
    endfunction

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst = 0;
        tick();
        t_reset();
        t_single_read();
        t_parked();
        t_addr_block();
        t_addr_retry();
        t_reorder();
        t_in_order_full();
        t_burst();
        t_data_retry();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule